// File: doc/BRIEF.md
# Edge-Triggered Timestamp Capture

This block records when an external event happens. It watches an asynchronous input pin and, on the chosen transition of that pin, copies the value of a free-running counter (supplied from outside) into a capture register. The pin is first brought into the clock domain by a flop chain. An optional glitch filter can then be placed in the path. The filter passes a new level only after a fixed number of consecutive synchronised samples agree on it, so short spikes never reach the edge detector.

Each capture sets a sticky flag. Software clears the flag with a write-one strobe. The flag drives an interrupt request when the interrupt enable is set. A capture-disable input stops all captures. It is used while the capture register holds the counter's period limit instead of a timestamp. The edge polarity can be changed at any time. A change of polarity on its own never counts as an event, because the detector compares the current level with the level one cycle earlier.

Top module: `evt_stamp_capture`

## Requirements
- R1: With the filter off, a pin transition that is set up before clock edge k is captured at edge k+2. This is two synchroniser flops. The value stored is the `count_val` present at edge k+2.
- R2: With the filter on, a new pin level is passed only after FILT_SAMPLES (default 4) consecutive synchronised samples agree on it. A pulse shorter than that causes no capture.
- R3: With the filter on, a qualifying transition is captured FILT_SAMPLES (4) edges later than with the filter off, that is at edge k+6.
- R4: `edge_rise`=1 selects low-to-high transitions and `edge_rise`=0 selects high-to-low transitions. A transition of the other direction causes no capture.
- R5: `cap_value` loads `count_val` in the cycle of a capture event and holds its value in every other cycle.
- R6: `cap_flag` is set by a capture and stays set until `flag_clr`=1. When a capture and a clear fall in the same cycle, the capture wins and the flag stays set.
- R7: `irq` is high exactly when `cap_flag`=1 and `irq_en`=1.
- R8: While `cap_block`=1, a selected transition changes neither `cap_value` nor `cap_flag`.
- R9: Toggling `edge_rise` while the pin level is steady causes no capture.
- R10: After reset, `cap_value`=0, `cap_flag`=0 and `irq`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_raw | input | 1 | Asynchronous event pin |
| count_val | input | CNT_W | Free-running counter value to timestamp |
| filt_en | input | 1 | 1 = route the pin through the glitch filter |
| edge_rise | input | 1 | 1 = rising transitions capture, 0 = falling |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Write-one strobe that clears the capture flag |
| cap_block | input | 1 | 1 = suppress all capture events |
| cap_value | output | CNT_W | Captured counter value |
| cap_flag | output | 1 | Sticky capture flag |
| irq | output | 1 | Interrupt request |

## Verification
The filter property assumes that the synchronised pin level is the only input to the filter. It also assumes that the run of agreeing samples the checker counts begins at reset, with both the filter history and the checker's record of the previous sample starting at low. The bench therefore holds the pin low through reset. The edge-based properties assume that `filt_en` is changed only while the synchronised pin and the filter output agree, so switching the source never creates a false edge. The bench changes `filt_en`, `edge_rise` and `cap_block` only after the pin has been steady for at least a dozen cycles.

// File: rtl/evt_stamp_pkg.sv
package evt_stamp_pkg;

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_kind_e;

  // True when the lowest n bits of win are all ones or all zeros.
  function automatic logic window_agree(input logic [31:0] win, input int n);
    logic ones;
    logic zeros;
    ones  = 1'b1;
    zeros = 1'b1;
    for (int i = 0; i < 32; i++) begin
      if (i < n) begin
        ones  = ones & win[i];
        zeros = zeros & ~win[i];
      end
    end
    return ones | zeros;
  endfunction

  // True when the level moved in the direction that kind asks for.
  function automatic logic edge_hit(input logic cur, input logic prev,
                                    input edge_kind_e kind);
    logic rose;
    logic fell;
    rose = cur & ~prev;
    fell = ~cur & prev;
    return (kind == EDGE_RISE) ? rose : fell;
  endfunction

endpackage

// File: rtl/evs_sync.sv
module evs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;
  logic [STAGES:0]   nxt;

  assign nxt = {chain, din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= nxt[STAGES-1:0];
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/evs_filter.sv
module evs_filter
  import evt_stamp_pkg::*;
#(
  parameter int SAMPLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic filt_q;

  generate
    if (SAMPLES < 2) begin : g_pass
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) filt_q <= 1'b0;
        else        filt_q <= din;
      end
    end else begin : g_vote
      logic [SAMPLES-2:0] hist;
      logic [SAMPLES-1:0] win;
      logic               agree;

      assign win   = {hist, din};
      assign agree = window_agree(32'(win), SAMPLES);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hist   <= '0;
          filt_q <= 1'b0;
        end else begin
          hist <= win[SAMPLES-2:0];
          if (agree) filt_q <= din;
        end
      end
    end
  endgenerate

  assign dout = filt_q;
endmodule

// File: rtl/evs_edge.sv
module evs_edge
  import evt_stamp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic edge_rise,
  input  logic cap_block,
  output logic lvl_prev,
  output logic evt
);
  edge_kind_e kind;
  logic       hit;

  assign kind = edge_kind_e'(edge_rise);
  assign hit  = edge_hit(lvl, lvl_prev, kind);
  assign evt  = hit & ~cap_block;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_prev <= 1'b0;
    else        lvl_prev <= lvl;
  end
endmodule

// File: rtl/evs_capture.sv
module evs_capture #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic [CNT_W-1:0] count_val,
  input  logic             flag_clr,
  input  logic             irq_en,
  output logic [CNT_W-1:0] cap_value,
  output logic             cap_flag,
  output logic             irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_value <= '0;
      cap_flag  <= 1'b0;
    end else begin
      if (evt) begin
        cap_value <= count_val;
        cap_flag  <= 1'b1;
      end else if (flag_clr) begin
        cap_flag <= 1'b0;
      end
    end
  end

  assign irq = cap_flag & irq_en;
endmodule

// File: rtl/evt_stamp_capture.sv
module evt_stamp_capture #(
  parameter int CNT_W        = 16,
  parameter int SYNC_STAGES  = 2,
  parameter int FILT_SAMPLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_raw,
  input  logic [CNT_W-1:0] count_val,
  input  logic             filt_en,
  input  logic             edge_rise,
  input  logic             irq_en,
  input  logic             flag_clr,
  input  logic             cap_block,
  output logic [CNT_W-1:0] cap_value,
  output logic             cap_flag,
  output logic             irq
);
  // Named internal events, brought out for the checker
  logic sync_lvl;
  logic filt_lvl;
  logic sel_lvl;
  logic prev_lvl;
  logic cap_evt;

  evs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pin_raw), .dout(sync_lvl)
  );

  evs_filter #(.SAMPLES(FILT_SAMPLES)) u_filt (
    .clk(clk), .rst_n(rst_n), .din(sync_lvl), .dout(filt_lvl)
  );

  assign sel_lvl = filt_en ? filt_lvl : sync_lvl;

  evs_edge u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(sel_lvl), .edge_rise(edge_rise),
    .cap_block(cap_block), .lvl_prev(prev_lvl), .evt(cap_evt)
  );

  evs_capture #(.CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .evt(cap_evt), .count_val(count_val),
    .flag_clr(flag_clr), .irq_en(irq_en), .cap_value(cap_value),
    .cap_flag(cap_flag), .irq(irq)
  );
endmodule

// File: rtl/evt_stamp_chk.sv
module evt_stamp_chk #(
  parameter int CNT_W        = 16,
  parameter int FILT_SAMPLES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] count_val,
  input logic             irq_en,
  input logic             flag_clr,
  input logic             cap_block,
  input logic [CNT_W-1:0] cap_value,
  input logic             cap_flag,
  input logic             irq,
  input logic             sync_lvl,
  input logic             filt_lvl,
  input logic             sel_lvl,
  input logic             prev_lvl,
  input logic             cap_evt
);
  // Length of the current run of identical synchronised samples
  logic [7:0] run_len;
  logic       sync_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= 8'd0;
      sync_d  <= 1'b0;
    end else begin
      sync_d <= sync_lvl;
      if (sync_lvl != sync_d) run_len <= 8'd1;
      else if (run_len != 8'hFF) run_len <= run_len + 8'd1;
    end
  end

  // R2
  filt_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_lvl != $past(filt_lvl)) |-> (int'(run_len) >= FILT_SAMPLES));

  // R5
  cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (cap_value == $past(count_val)));

  // R5
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> $stable(cap_value));

  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> cap_flag);

  // R6
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !cap_evt) |=> !cap_flag);

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_flag && !flag_clr) |=> cap_flag);

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en && cap_flag));

  // R7
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_flag && irq_en) |-> irq);

  // R8
  block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_block |-> !cap_evt);

  // R9
  steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_lvl == prev_lvl) |-> !cap_evt);
endmodule

bind evt_stamp_capture evt_stamp_chk #(
  .CNT_W(CNT_W), .FILT_SAMPLES(FILT_SAMPLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .count_val(count_val), .irq_en(irq_en),
  .flag_clr(flag_clr), .cap_block(cap_block), .cap_value(cap_value),
  .cap_flag(cap_flag), .irq(irq), .sync_lvl(sync_lvl), .filt_lvl(filt_lvl),
  .sel_lvl(sel_lvl), .prev_lvl(prev_lvl), .cap_evt(cap_evt)
);

// File: tb/evt_stamp_capture_bench.sv
module evt_stamp_capture_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin_raw = 1'b0;
  logic [15:0] count_val = 16'd0;
  logic        filt_en = 1'b0;
  logic        edge_rise = 1'b1;
  logic        irq_en = 1'b0;
  logic        flag_clr = 1'b0;
  logic        cap_block = 1'b0;
  logic [15:0] cap_value;
  logic        cap_flag;
  logic        irq;

  int          n_chk = 0;
  int          n_bad = 0;
  logic [15:0] exp_q[$];
  logic [15:0] last_cap = 16'd0;
  bit          done = 1'b0;

  evt_stamp_capture u_evt_stamp_capture (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .count_val(count_val),
    .filt_en(filt_en), .edge_rise(edge_rise), .irq_en(irq_en),
    .flag_clr(flag_clr), .cap_block(cap_block), .cap_value(cap_value),
    .cap_flag(cap_flag), .irq(irq)
  );

  always #10 clk = ~clk;

  initial forever begin
    @(posedge clk);
    count_val <= count_val + 16'd1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // Scoreboard monitor: every change of cap_value must match the queue head
  initial forever begin
    @(negedge clk);
    if (rst_n && cap_value != last_cap) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5", "unexpected capture", cap_value, last_cap);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check(cap_value == e, "R1/R3/R5", "captured count", cap_value, e);
      end
      last_cap = cap_value;
    end
  end

  // Latency from pin change at a falling edge to the capturing rising edge
  function automatic logic [15:0] lat();
    return filt_en ? 16'd6 : 16'd2;
  endfunction

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Drive a new pin level; expect a capture if cap is set
  task automatic drive_pin(input logic val, input bit cap);
    @(negedge clk);
    pin_raw = val;
    if (cap) exp_q.push_back(count_val + lat());
    settle(12);
  endtask

  // High pulse of width cycles, then low
  task automatic pulse_pin(input int width, input bit cap);
    @(negedge clk);
    pin_raw = 1'b1;
    if (cap) exp_q.push_back(count_val + lat());
    settle(width);
    pin_raw = 1'b0;
    settle(14);
  endtask

  task automatic clear_flag();
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  initial begin
    logic [15:0] held;
    settle(3);
    // R10 reset state
    check(cap_value == 16'd0, "R10", "cap_value after reset", cap_value, 0);
    check(cap_flag == 1'b0, "R10", "cap_flag after reset", cap_flag, 0);
    check(irq == 1'b0, "R10", "irq after reset", irq, 0);
    rst_n = 1'b1;
    settle(4);

    // R1 R4: rising capture, unfiltered
    drive_pin(1'b1, 1'b1);
    check(cap_flag == 1'b1, "R6", "flag after capture", cap_flag, 1);
    check(irq == 1'b0, "R7", "irq with enable off", irq, 0);
    irq_en = 1'b1;
    #1;
    check(irq == 1'b1, "R7", "irq with enable on", irq, 1);
    held = cap_value;
    drive_pin(1'b0, 1'b0);  // R4 falling ignored under rising select
    check(cap_value == held, "R4", "opposite edge ignored", cap_value, held);
    clear_flag();
    check(cap_flag == 1'b0, "R6", "flag after clear", cap_flag, 0);
    check(irq == 1'b0, "R7", "irq after clear", irq, 0);

    // R9: toggling edge select with steady pin
    @(negedge clk); edge_rise = 1'b0;
    settle(3);
    @(negedge clk); edge_rise = 1'b1;
    settle(3);
    @(negedge clk); edge_rise = 1'b0;
    settle(5);
    check(cap_flag == 1'b0, "R9", "no capture from select toggle", cap_flag, 0);

    // R4: falling select
    drive_pin(1'b1, 1'b0);
    check(cap_flag == 1'b0, "R4", "rising ignored under falling select", cap_flag, 0);
    drive_pin(1'b0, 1'b1);
    check(cap_flag == 1'b1, "R4", "falling captured", cap_flag, 1);

    // R6: clear coinciding with capture
    @(negedge clk); edge_rise = 1'b1;
    settle(4);
    @(negedge clk);
    pin_raw = 1'b1;
    exp_q.push_back(count_val + 16'd2);
    @(negedge clk);
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    check(cap_flag == 1'b1, "R6", "capture wins over clear", cap_flag, 1);
    settle(8);
    clear_flag();
    check(cap_flag == 1'b0, "R6", "plain clear", cap_flag, 0);

    // R8: capture blocked
    drive_pin(1'b0, 1'b0);
    @(negedge clk); cap_block = 1'b1;
    held = cap_value;
    drive_pin(1'b1, 1'b0);
    check(cap_flag == 1'b0, "R8", "flag under block", cap_flag, 0);
    check(cap_value == held, "R8", "value under block", cap_value, held);
    @(negedge clk); cap_block = 1'b0;
    drive_pin(1'b0, 1'b0);

    // R2 R3: filtered path
    @(negedge clk); filt_en = 1'b1;
    settle(6);
    held = cap_value;
    pulse_pin(3, 1'b0);
    check(cap_value == held, "R2", "short pulse filtered", cap_value, held);
    check(cap_flag == 1'b0, "R2", "no flag from short pulse", cap_flag, 0);
    pulse_pin(4, 1'b1);
    check(cap_flag == 1'b1, "R3", "filtered pulse captured", cap_flag, 1);
    clear_flag();
    @(negedge clk); edge_rise = 1'b0;
    settle(4);
    drive_pin(1'b1, 1'b0);
    drive_pin(1'b0, 1'b1);
    check(cap_flag == 1'b1, "R3", "filtered falling captured", cap_flag, 1);

    settle(4);
    check(exp_q.size() == 0, "R5", "pending expected captures", exp_q.size(), 0);
    done = 1'b1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, "WDOG", "watchdog expired", 0, 1);
      report();
    end
  end
endmodule